// File: doc/BRIEF.md
# Windowed Message FIFO Pair

This block gives a CPU two four-entry message queues, one for sending and one for receiving. The CPU never sees the queue pointers. It reaches each queue through a single fixed byte window that always shows one entry. On the send side the window shows the slot that will be queued next. The CPU fills in identifier, length and data bytes there, then writes the advance key to a pointer register, and the entry joins the queue. On the receive side the window shows the oldest stored frame. The CPU reads it and writes the advance key to release it.

The protocol engine is not part of this block. It is replaced by two simple handshakes. A consumer takes the head send frame from `tx_valid`/`tx_done`. A producer offers received frames with a single-cycle `rx_push`. Per-queue enable bits, an unsent-message count, an empty flag and a sticky send-overflow flag give the CPU its view of the queues. Two interrupt status bits, gated by enable bits, raise the interrupt lines. A full receive queue drops the new frame and reports an overrun pulse to the error logic.

Byte map: 0x00-0x0E send window, 0x10-0x1E receive window, 0x20 send control, 0x21 send pointer, 0x22 receive control, 0x23 receive pointer, 0x24 interrupt enable, 0x25 interrupt status. Every other address reads as zero. Window byte offsets: 0-3 hold identifier bits 7:0, 15:8, 23:16 and 31:24. Offset 4 holds the length code in bits 3:0. Offsets 5-12 hold data bytes 0-7. Offset 13 holds timestamp bits 15:8 and offset 14 holds timestamp bits 7:0.

Top module: `mbwin_fifo_top`

## Requirements
- R1: After reset both enables are 0, the unsent count is 0, the receive empty flag is 1, both interrupt status bits and lines are 0, `tx_valid` is 0 and `rx_overrun` is 0. The send control register reads 0x00 and the receive control register reads 0x80.
- R2: Bytes written to the send window read back at the same offsets. The identifier, length code and data of a queued entry reach `tx_id`, `tx_len` and `tx_data` unchanged. Data byte k sits at `tx_data[8k+7:8k]`. Identifier bit 31 marks an extended identifier (29 bits in 28:0), and a standard 11-bit identifier sits at bits 28:18.
- R3: Writing exactly 0xFF to 0x21 while the send queue is enabled (0x20 bit 0) queues the window entry. The count in 0x20 bits 3:1 rises by one and `tx_valid` is high from the next cycle. Any other value written, or any write while the send queue is disabled, leaves the queue unchanged.
- R4: With 4 entries unsent, a 0xFF advance is ignored and sets the sticky overflow flag in 0x20 bit 7, which only reset clears. Send window writes are also ignored while the queue is full.
- R5: Frames leave in the order they were queued. Each cycle with `tx_valid` and `tx_done` both high removes one frame and lowers the unsent count. The head frame holds steady while it waits.
- R6: When identifier bit 30 (remote request) of the head send frame is set, `tx_data` is all zero.
- R7: A push accepted by the enabled receive queue (0x22 bit 0) clears the empty flag (0x22 bit 7). The receive window then shows the oldest frame, including its 16-bit timestamp. Writing 0xFF to 0x23 releases that frame. The same write to an empty queue changes nothing.
- R8: A push into a full, enabled receive queue is dropped and leaves the stored frames as they were. `rx_overrun` is high for exactly the one cycle after that push.
- R9: A received frame whose identifier bit 30 is set is stored with all data bytes zero. Its identifier, length code and timestamp are kept.
- R10: Status bit 3 of 0x25 is set when a send frame completes, and bit 4 when a receive push is accepted. Each is set only if the matching bit in 0x24 is set. Writing 0 to a status bit clears it, and writing 1 leaves it as it is. `irq_tx` and `irq_rx` show bits 3 and 4.
- R11: While the receive queue is disabled, pushes are neither stored nor counted as overruns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 6 | CPU byte address |
| cpu_we | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte, combinational from `cpu_addr` |
| tx_valid | output | 1 | A send frame is waiting at the head |
| tx_id | output | 32 | Head send frame identifier word |
| tx_len | output | 4 | Head send frame length code |
| tx_data | output | 64 | Head send frame data, byte k at bits 8k+7:8k |
| tx_done | input | 1 | Consumer has finished the head frame |
| rx_push | input | 1 | Producer offers a received frame |
| rx_id | input | 32 | Received identifier word |
| rx_len | input | 4 | Received length code |
| rx_data | input | 64 | Received data bytes |
| rx_ts | input | 16 | Received timestamp |
| irq_tx | output | 1 | Send-complete interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| rx_overrun | output | 1 | One-cycle pulse on a dropped receive frame |

## Verification
Every register update lands on the clock edge that samples the write or handshake. The unsent count, empty flag, `tx_valid`, status bits and `rx_overrun` are therefore due one edge after the stimulus. Window reads are combinational and are due in the same cycle the address is set. The bench drives every stimulus on a falling edge so that exactly one rising edge acts on it. It reads results on the following falling edge, and it never reads across more than the edge it is checking. The overrun pulse is checked both on the falling edge right after the dropping push and one cycle later, to confirm it is exactly one cycle wide.

// File: rtl/mbwin_pkg.sv
package mbwin_pkg;

    typedef struct packed {
        logic [31:0]     id;
        logic [3:0]      len;
        logic [7:0][7:0] data;
        logic [15:0]     ts;
    } mb_entry_t;

    localparam logic [5:0] A_TX_CTL = 6'h20;
    localparam logic [5:0] A_TX_PTR = 6'h21;
    localparam logic [5:0] A_RX_CTL = 6'h22;
    localparam logic [5:0] A_RX_PTR = 6'h23;
    localparam logic [5:0] A_IRQ_EN = 6'h24;
    localparam logic [5:0] A_IRQ_ST = 6'h25;
    localparam logic [7:0] ADV_KEY  = 8'hFF;

    // Byte view of one entry as seen through a window.
    function automatic logic [7:0] entry_get(mb_entry_t e, logic [3:0] off);
        logic [7:0] b;
        b = '0;
        case (off)
            4'd0:  b = e.id[7:0];
            4'd1:  b = e.id[15:8];
            4'd2:  b = e.id[23:16];
            4'd3:  b = e.id[31:24];
            4'd4:  b = {4'b0000, e.len};
            4'd13: b = e.ts[15:8];
            4'd14: b = e.ts[7:0];
            default: if (off >= 4'd5 && off <= 4'd12) b = e.data[3'(off - 4'd5)];
        endcase
        return b;
    endfunction

    function automatic mb_entry_t entry_put(mb_entry_t e, logic [3:0] off, logic [7:0] v);
        mb_entry_t r;
        r = e;
        case (off)
            4'd0:  r.id[7:0]   = v;
            4'd1:  r.id[15:8]  = v;
            4'd2:  r.id[23:16] = v;
            4'd3:  r.id[31:24] = v;
            4'd4:  r.len       = v[3:0];
            4'd13: r.ts[15:8]  = v;
            4'd14: r.ts[7:0]   = v;
            default: if (off >= 4'd5 && off <= 4'd12) r.data[3'(off - 4'd5)] = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mbwin_ptrs.sv
module mbwin_ptrs #(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_st_t;

    ptr_st_t s_d, s_q;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) s_d.wr = step(s_q.wr);
        if (pop)  s_d.rd = step(s_q.rd);
        s_d.cnt = s_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_ptr = s_q.wr;
    assign rd_ptr = s_q.rd;
    assign count  = s_q.cnt;
endmodule

// File: rtl/mbwin_ring.sv
module mbwin_ring
    import mbwin_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bw_en,
    input  logic [PTR_W-1:0]      bw_slot,
    input  logic [3:0]            bw_off,
    input  logic [7:0]            bw_val,
    input  logic                  ew_en,
    input  logic [PTR_W-1:0]      ew_slot,
    input  mb_entry_t             ew_val,
    output mb_entry_t [DEPTH-1:0] slots
);
    mb_entry_t [DEPTH-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (bw_en && bw_slot == PTR_W'(i)) mem_d[i] = entry_put(mem_q[i], bw_off, bw_val);
            if (ew_en && ew_slot == PTR_W'(i)) mem_d[i] = ew_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign slots = mem_q;
endmodule

// File: rtl/mbwin_fifo_top.sv
module mbwin_fifo_top
    import mbwin_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  cpu_addr,
    input  logic        cpu_we,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        tx_valid,
    output logic [31:0] tx_id,
    output logic [3:0]  tx_len,
    output logic [63:0] tx_data,
    input  logic        tx_done,
    input  logic        rx_push,
    input  logic [31:0] rx_id,
    input  logic [3:0]  rx_len,
    input  logic [63:0] rx_data,
    input  logic [15:0] rx_ts,
    output logic        irq_tx,
    output logic        irq_rx,
    output logic        rx_overrun
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic tx_en;
        logic rx_en;
        logic tx_ovf;
        logic ie_tx;
        logic ie_rx;
        logic is_tx;
        logic is_rx;
        logic ovr;
    } ctl_st_t;

    ctl_st_t r_d, r_q;

    logic [PTR_W-1:0] tx_wr, tx_rd, rx_wr, rx_rd;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    mb_entry_t [DEPTH-1:0] tx_slots, rx_slots;
    mb_entry_t rx_entry, tx_head;

    logic tx_full, tx_empty, rx_full, rx_empty;
    logic txwin_wr, tx_adv, tx_push, tx_pop;
    logic rx_take, rx_drop, rx_adv, st_wr;
    logic [2:0] unsent3;

    assign tx_full  = (tx_cnt == CNT_W'(DEPTH));
    assign tx_empty = (tx_cnt == '0);
    assign rx_full  = (rx_cnt == CNT_W'(DEPTH));
    assign rx_empty = (rx_cnt == '0);

    assign txwin_wr = cpu_we && (cpu_addr[5:4] == 2'b00) && (cpu_addr[3:0] != 4'hF) && !tx_full;
    assign tx_adv   = cpu_we && (cpu_addr == A_TX_PTR) && (cpu_wdata == ADV_KEY) && r_q.tx_en;
    assign tx_push  = tx_adv && !tx_full;
    assign tx_pop   = tx_valid && tx_done;
    assign rx_take  = rx_push && r_q.rx_en && !rx_full;
    assign rx_drop  = rx_push && r_q.rx_en && rx_full;
    assign rx_adv   = cpu_we && (cpu_addr == A_RX_PTR) && (cpu_wdata == ADV_KEY) && !rx_empty;
    assign st_wr    = cpu_we && (cpu_addr == A_IRQ_ST);
    assign unsent3  = 3'(tx_cnt);

    // Remote requests carry no payload into the queue.
    always_comb begin
        rx_entry.id   = rx_id;
        rx_entry.len  = rx_len;
        rx_entry.data = rx_id[30] ? '0 : rx_data;
        rx_entry.ts   = rx_ts;
    end

    mbwin_ptrs #(.DEPTH(DEPTH)) u_tx_ptrs (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
        .wr_ptr(tx_wr), .rd_ptr(tx_rd), .count(tx_cnt)
    );

    mbwin_ptrs #(.DEPTH(DEPTH)) u_rx_ptrs (
        .clk(clk), .rst_n(rst_n), .push(rx_take), .pop(rx_adv),
        .wr_ptr(rx_wr), .rd_ptr(rx_rd), .count(rx_cnt)
    );

    mbwin_ring #(.DEPTH(DEPTH)) u_tx_ring (
        .clk(clk), .rst_n(rst_n),
        .bw_en(txwin_wr), .bw_slot(tx_wr), .bw_off(cpu_addr[3:0]), .bw_val(cpu_wdata),
        .ew_en(1'b0), .ew_slot('0), .ew_val('0),
        .slots(tx_slots)
    );

    mbwin_ring #(.DEPTH(DEPTH)) u_rx_ring (
        .clk(clk), .rst_n(rst_n),
        .bw_en(1'b0), .bw_slot('0), .bw_off(4'd0), .bw_val(8'd0),
        .ew_en(rx_take), .ew_slot(rx_wr), .ew_val(rx_entry),
        .slots(rx_slots)
    );

    always_comb begin
        r_d = r_q;
        if (cpu_we && cpu_addr == A_TX_CTL) r_d.tx_en = cpu_wdata[0];
        if (cpu_we && cpu_addr == A_RX_CTL) r_d.rx_en = cpu_wdata[0];
        if (cpu_we && cpu_addr == A_IRQ_EN) begin
            r_d.ie_tx = cpu_wdata[3];
            r_d.ie_rx = cpu_wdata[4];
        end
        if (tx_adv && tx_full) r_d.tx_ovf = 1'b1;
        r_d.is_tx = (r_q.is_tx && !(st_wr && !cpu_wdata[3])) || (r_q.ie_tx && tx_pop);
        r_d.is_rx = (r_q.is_rx && !(st_wr && !cpu_wdata[4])) || (r_q.ie_rx && rx_take);
        r_d.ovr   = rx_drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr[5:4] == 2'b00)      cpu_rdata = entry_get(tx_slots[tx_wr], cpu_addr[3:0]);
        else if (cpu_addr[5:4] == 2'b01) cpu_rdata = entry_get(rx_slots[rx_rd], cpu_addr[3:0]);
        else begin
            case (cpu_addr)
                A_TX_CTL: cpu_rdata = {r_q.tx_ovf, 3'b000, unsent3, r_q.tx_en};
                A_RX_CTL: cpu_rdata = {rx_empty, 6'b000000, r_q.rx_en};
                A_IRQ_EN: cpu_rdata = {3'b000, r_q.ie_rx, r_q.ie_tx, 3'b000};
                A_IRQ_ST: cpu_rdata = {3'b000, r_q.is_rx, r_q.is_tx, 3'b000};
                default:  cpu_rdata = '0;
            endcase
        end
    end

    assign tx_head    = tx_slots[tx_rd];
    assign tx_valid   = r_q.tx_en && !tx_empty;
    assign tx_id      = tx_head.id;
    assign tx_len     = tx_head.len;
    assign tx_data    = tx_head.id[30] ? '0 : tx_head.data;
    assign irq_tx     = r_q.is_tx;
    assign irq_rx     = r_q.is_rx;
    assign rx_overrun = r_q.ovr;
endmodule

// File: rtl/mbwin_fifo_chk.sv
module mbwin_fifo_chk
    import mbwin_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_we,
    input logic [5:0]       cpu_addr,
    input logic             tx_valid,
    input logic             tx_done,
    input logic [31:0]      tx_id,
    input logic [3:0]       tx_len,
    input logic             rx_push,
    input logic             rx_overrun,
    input logic             irq_tx,
    input logic             irq_rx,
    input logic [CNT_W-1:0] unsent
);
    p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> $past(rx_push));

    p_txirq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_tx) |-> $past(tx_valid && tx_done));

    p_rxirq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rx) |-> $past(rx_push));

    p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_done && !(cpu_we && cpu_addr == A_TX_CTL))
        |=> (tx_valid && $stable(tx_id) && $stable(tx_len)));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == A_TX_PTR && unsent == CNT_W'(DEPTH) && !(tx_valid && tx_done))
        |=> (unsent == CNT_W'(DEPTH)));

    p_unsent_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        unsent <= CNT_W'(DEPTH));
endmodule

bind mbwin_fifo_top mbwin_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .tx_valid(tx_valid), .tx_done(tx_done), .tx_id(tx_id), .tx_len(tx_len),
    .rx_push(rx_push), .rx_overrun(rx_overrun), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .unsent(tx_cnt)
);

// File: tb/sim_mbwin_fifo_top.sv
`timescale 1ns/1ps
module sim_mbwin_fifo_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        tx_valid;
    logic [31:0] tx_id;
    logic [3:0]  tx_len;
    logic [63:0] tx_data;
    logic        tx_done = 1'b0;
    logic        rx_push = 1'b0;
    logic [31:0] rx_id = '0;
    logic [3:0]  rx_len = '0;
    logic [63:0] rx_data = '0;
    logic [15:0] rx_ts = '0;
    logic        irq_tx, irq_rx, rx_overrun;

    typedef struct {
        logic [31:0] id;
        logic [3:0]  len;
        logic [63:0] data;
        logic [15:0] ts;
    } frm_t;

    frm_t txq[$];
    frm_t rxq[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   consume = 1'b0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    mbwin_fifo_top u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    // Fill the send window, then advance; the expected frame goes to the scoreboard.
    task automatic tx_send(input logic [31:0] id, input logic [3:0] len, input logic [63:0] data);
        frm_t f;
        for (int k = 0; k < 4; k++) cpu_wr(6'(k), id[8*k +: 8]);
        cpu_wr(6'd4, {4'b0, len});
        for (int k = 0; k < 8; k++) cpu_wr(6'(5 + k), data[8*k +: 8]);
        cpu_wr(6'h21, 8'hFF);
        f.id = id; f.len = len; f.data = id[30] ? 64'd0 : data; f.ts = 16'd0;
        txq.push_back(f);
    endtask

    task automatic rx_offer(input logic [31:0] id, input logic [3:0] len, input logic [63:0] data,
                            input logic [15:0] ts, input bit accept);
        frm_t f;
        @(negedge clk);
        rx_id = id; rx_len = len; rx_data = data; rx_ts = ts; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
        if (accept) begin
            f.id = id; f.len = len; f.data = id[30] ? 64'd0 : data; f.ts = ts;
            rxq.push_back(f);
        end
    endtask

    // Read the receive window, compare with the scoreboard head, release it.
    task automatic rx_take(input string tag);
        frm_t e;
        logic [7:0]  b;
        logic [31:0] id;
        logic [3:0]  len;
        logic [63:0] data;
        logic [15:0] ts;
        for (int k = 0; k < 4; k++) begin cpu_rd(6'(16 + k), b); id[8*k +: 8] = b; end
        cpu_rd(6'h14, b); len = b[3:0];
        for (int k = 0; k < 8; k++) begin cpu_rd(6'(21 + k), b); data[8*k +: 8] = b; end
        cpu_rd(6'h1D, b); ts[15:8] = b;
        cpu_rd(6'h1E, b); ts[7:0] = b;
        if (rxq.size() == 0) chk({tag, " scoreboard empty"}, 64'd1, 64'd0);
        else begin
            e = rxq.pop_front();
            chk({tag, " id"}, 64'(id), 64'(e.id));
            chk({tag, " len"}, 64'(len), 64'(e.len));
            chk({tag, " data"}, data, e.data);
            chk({tag, " ts"}, 64'(ts), 64'(e.ts));
        end
        cpu_wr(6'h23, 8'hFF);
    endtask

    // Send-side monitor: consumes head frames and compares them in order.
    initial begin
        frm_t e;
        forever begin
            @(negedge clk);
            if (tx_done) tx_done = 1'b0;
            else if (consume && tx_valid) begin
                if (txq.size() == 0) chk("R5 unexpected frame", 64'd1, 64'd0);
                else begin
                    e = txq.pop_front();
                    chk("R2 tx_id", 64'(tx_id), 64'(e.id));
                    chk("R5 tx_len order", 64'(tx_len), 64'(e.len));
                    chk("R6 tx_data", tx_data, e.data);
                end
                tx_done = 1'b1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cpu_rd(6'h20, v); chk("R1 tx ctl", 64'(v), 64'h00);
        cpu_rd(6'h22, v); chk("R1 rx ctl", 64'(v), 64'h80);
        cpu_rd(6'h25, v); chk("R1 irq status", 64'(v), 64'h00);
        chk("R1 tx_valid", 64'(tx_valid), 64'd0);
        chk("R1 irq lines", 64'({irq_tx, irq_rx, rx_overrun}), 64'd0);

        cpu_wr(6'h24, 8'h18);
        cpu_wr(6'h20, 8'h01);
        cpu_wr(6'h22, 8'h01);

        // R2 window readback, R3 advance key
        for (int k = 0; k < 4; k++) cpu_wr(6'(k), 8'(32'h048C0000 >> (8*k)));
        cpu_wr(6'd4, 8'h08);
        for (int k = 0; k < 8; k++) cpu_wr(6'(5 + k), 8'(64'h8877665544332211 >> (8*k)));
        cpu_rd(6'h03, v); chk("R2 readback id[31:24]", 64'(v), 64'h04);
        cpu_rd(6'h0C, v); chk("R2 readback data7", 64'(v), 64'h88);
        cpu_wr(6'h21, 8'h7F);
        cpu_rd(6'h20, v); chk("R3 non-key advance", 64'(v), 64'h01);
        chk("R3 tx_valid idle", 64'(tx_valid), 64'd0);
        cpu_wr(6'h21, 8'hFF);
        begin frm_t f; f.id = 32'h048C0000; f.len = 4'd8; f.data = 64'h8877665544332211; f.ts = '0; txq.push_back(f); end
        chk("R3 tx_valid after advance", 64'(tx_valid), 64'd1);
        cpu_rd(6'h20, v); chk("R3 unsent 1", 64'(v), 64'h03);

        tx_send(32'h9ABCDEF1, 4'd3, 64'h0000000000CCBBAA);
        tx_send(32'h5FFC0000, 4'd2, 64'hDEADBEEFCAFEF00D);
        tx_send(32'h00040000, 4'd1, 64'h0000000000000001);
        cpu_rd(6'h20, v); chk("R3 unsent 4", 64'(v), 64'h09);

        // R4 full: window write and advance ignored
        cpu_wr(6'h00, 8'h55);
        cpu_rd(6'h00, v); chk("R4 window write while full", 64'(v), 64'h00);
        cpu_wr(6'h21, 8'hFF);
        cpu_rd(6'h20, v); chk("R4 overflow flag", 64'(v), 64'h89);

        // R5 drain in order
        consume = 1'b1;
        for (int g = 0; g < 200 && txq.size() != 0; g++) @(negedge clk);
        repeat (3) @(negedge clk);
        consume = 1'b0;
        chk("R5 all frames sent", 64'(txq.size()), 64'd0);
        cpu_rd(6'h20, v); chk("R5 unsent 0, sticky ovf", 64'(v), 64'h81);
        chk("R5 tx_valid after drain", 64'(tx_valid), 64'd0);

        // R10 status write-one keeps, write-zero clears
        chk("R10 irq_tx set", 64'(irq_tx), 64'd1);
        cpu_wr(6'h25, 8'h08);
        chk("R10 write 1 keeps", 64'(irq_tx), 64'd1);
        cpu_wr(6'h25, 8'h00);
        chk("R10 write 0 clears", 64'(irq_tx), 64'd0);

        // R3 disabled queue ignores advance
        cpu_wr(6'h20, 8'h00);
        cpu_wr(6'h21, 8'hFF);
        cpu_rd(6'h20, v); chk("R3 disabled advance", 64'(v), 64'h80);
        chk("R3 disabled tx_valid", 64'(tx_valid), 64'd0);

        // R7 receive path
        cpu_wr(6'h23, 8'hFF);
        cpu_rd(6'h22, v); chk("R7 advance while empty", 64'(v), 64'h81);
        rx_offer(32'h80000005, 4'd8, 64'h0102030405060708, 16'h1234, 1'b1);
        cpu_rd(6'h22, v); chk("R7 empty flag clears", 64'(v), 64'h01);
        chk("R10 irq_rx set", 64'(irq_rx), 64'd1);
        rx_offer(32'h41540000, 4'd4, 64'hFFFFFFFFFFFFFFFF, 16'h0042, 1'b1);
        rx_offer(32'h00080000, 4'd2, 64'h000000000000BEEF, 16'h0100, 1'b1);
        rx_offer(32'h9FFFFFFF, 4'd8, 64'hA5A5A5A55A5A5A5A, 16'hFFFF, 1'b1);

        // R8 overrun on full
        rx_offer(32'h12345678, 4'd5, 64'h1111111111111111, 16'h7777, 1'b0);
        chk("R8 overrun pulse", 64'(rx_overrun), 64'd1);
        @(negedge clk);
        chk("R8 overrun one cycle", 64'(rx_overrun), 64'd0);
        rx_take("R8/R7 frame 1");
        rx_take("R9 remote frame");
        rx_take("R7 frame 3");
        rx_take("R8 frame 4");
        cpu_rd(6'h22, v); chk("R7 empty after release", 64'(v), 64'h81);

        // R11 disabled receive
        cpu_wr(6'h22, 8'h00);
        rx_offer(32'h00000001, 4'd1, 64'h1, 16'h1, 1'b0);
        chk("R11 no overrun when disabled", 64'(rx_overrun), 64'd0);
        cpu_rd(6'h22, v); chk("R11 push ignored", 64'(v), 64'h80);

        // R10 enable gating
        cpu_wr(6'h25, 8'h00);
        cpu_wr(6'h24, 8'h00);
        cpu_wr(6'h22, 8'h01);
        rx_offer(32'h00C00000, 4'd3, 64'h0000000000332211, 16'h0ABC, 1'b1);
        chk("R10 irq_rx gated", 64'(irq_rx), 64'd0);
        cpu_rd(6'h25, v); chk("R10 status gated", 64'(v), 64'h00);
        rx_take("R7 frame after gating");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule